// File: doc/BRIEF.md
# DSI Video-Mode Line and Frame Timing Generator

This block produces the raster position of a display serial link running in video mode. Horizontal intervals are given in pixels and the link counts in lane byte-clock cycles, so the block first converts each horizontal interval. The conversion uses the bits per pixel of the selected colour format and the number of active data lanes. It then steps a byte counter and a line counter through every frame. Each cycle it reports which vertical region and which horizontal region the link is in. It also reports whether the lanes may drop to low power, and pulses a marker on the first byte of every frame.

All inputs are plain, level-held configuration pins. There is no data stream and no handshake. The counters never stall, and there is no back-pressure. The block samples its inputs only at a frame boundary, so software or an upstream controller may change them at any time. The new values take effect from the following frame onwards.

Top module: `dsi_vid_timing`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, `vreg` and `hreg` read 0, `lp_ok` reads 1 and `frame_start` reads 0. Counting starts on the clock edge that ends that first cycle.
- R2: `fmt` selects bits per pixel as follows: 0 is 24, 1 is 24, 2 is 18 and 3 is 16. `lanes_m1` holds the lane count minus one, so 0 to 3 stands for 1 to 4 lanes.
- R3: The sync, back-porch and active horizontal intervals each last floor(pixels × bpp / (8 × lanes)) byte cycles. They appear in that order, encoded in `hreg` as 0 for sync, 1 for back porch and 2 for active.
- R4: A line lasts floor((sync + back + active + front pixels) × bpp / (8 × lanes)) byte cycles, converted as one sum, with a result of 0 treated as 1. The cycles left over after the first three intervals are the front porch, encoded as `hreg` = 3.
- R5: Vertical intervals are counted in whole lines with no conversion, in the order sync, back porch, active and front porch. `vreg` encodes them as 0, 1, 2 and 3. A frame total of 0 lines is treated as 1.
- R6: `lp_ok` is 1 on every line outside vertical active. On vertical-active lines it is 1 during the horizontal back porch and 0 during horizontal sync and active.
- R7: During the horizontal front porch of a vertical-active line, `lp_ok` equals the sampled `burst` flag.
- R8: `frame_start` is 1 for exactly the cycle that holds byte 0 of line 0 of a frame, and is 0 otherwise.
- R9: All timing inputs, `fmt`, `lanes_m1` and `burst` are sampled only on the edge that ends the first cycle after reset, and on the edge that ends the last byte of a frame. Changes at any other time do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsa_px | input | PX_W | Horizontal sync width in pixels |
| hbp_px | input | PX_W | Horizontal back porch in pixels |
| hact_px | input | PX_W | Horizontal active width in pixels |
| hfp_px | input | PX_W | Horizontal front porch in pixels |
| vsa_ln | input | LN_W | Vertical sync in lines |
| vbp_ln | input | LN_W | Vertical back porch in lines |
| vact_ln | input | LN_W | Vertical active in lines |
| vfp_ln | input | LN_W | Vertical front porch in lines |
| fmt | input | 2 | Colour format selecting bits per pixel |
| lanes_m1 | input | 2 | Data lane count minus one |
| burst | input | 1 | Burst mode, permits low power in active-line front porch |
| vreg | output | 2 | Vertical region code |
| hreg | output | 2 | Horizontal region code |
| lp_ok | output | 1 | Low-power entry allowed this cycle |
| frame_start | output | 1 | First byte of a frame |

## Verification
The region codes, `lp_ok` and `frame_start` are decoded from registered counters, so each one belongs to the cycle after the rising edge that moved the counters. `frame_start` appears in the cycle after the edge that loaded the parameters. Changed inputs show up only in the frame that begins after the next frame-ending edge. The bench keeps a reference position that it advances once per rising edge, using the same sampling rule. It compares every output at the falling edge of every cycle. Checks made while inputs differ from the sampled values carry the R9 tag.

// File: rtl/dsi_tm_pkg.sv
package dsi_tm_pkg;
  typedef enum logic [1:0] {
    RG_SYNC  = 2'd0,
    RG_BACK  = 2'd1,
    RG_ACT   = 2'd2,
    RG_FRONT = 2'd3
  } region_e;

  // Bits per pixel for each colour format code (R2).
  function automatic logic [4:0] fmt_bpp(input logic [1:0] fmt);
    case (fmt)
      2'd0, 2'd1: fmt_bpp = 5'd24;
      2'd2:       fmt_bpp = 5'd18;
      default:    fmt_bpp = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/dsi_tm_conv.sv
// Pixel-to-byte-cycle conversion of the horizontal intervals.
module dsi_tm_conv #(
  parameter int PX_W = 12,
  parameter int BC_W = PX_W + 4
) (
  input  logic [2:0][PX_W-1:0] part_px,  // sync, back, active
  input  logic [PX_W-1:0]      front_px,
  input  logic [1:0]           fmt,
  input  logic [1:0]           lanes_m1,
  output logic [2:0][BC_W-1:0] part_b,
  output logic [BC_W-1:0]      line_b
);
  import dsi_tm_pkg::*;

  localparam int PR_W = PX_W + 7;
  localparam int SM_W = PX_W + 2;

  logic [PR_W-1:0] bpp_w;
  logic [PR_W-1:0] div_w;
  logic [SM_W-1:0] sum_px;
  logic [BC_W-1:0] line_raw;

  assign bpp_w = PR_W'(fmt_bpp(fmt));
  assign div_w = PR_W'({({1'b0, lanes_m1} + 3'd1), 3'b000});

  // Each partial interval is converted on its own (R3).
  for (genvar i = 0; i < 3; i++) begin : g_part
    assign part_b[i] = BC_W'((PR_W'(part_px[i]) * bpp_w) / div_w);
  end

  // The full line is converted as one sum (R4).
  assign sum_px   = SM_W'(part_px[0]) + SM_W'(part_px[1])
                  + SM_W'(part_px[2]) + SM_W'(front_px);
  assign line_raw = BC_W'((PR_W'(sum_px) * bpp_w) / div_w);
  assign line_b   = (line_raw == '0) ? BC_W'(1) : line_raw;
endmodule

// File: rtl/dsi_tm_hcnt.sv
// Byte counter within a line, with sampled horizontal boundaries.
module dsi_tm_hcnt #(
  parameter int BC_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 load,
  input  logic [2:0][BC_W-1:0] part_b,
  input  logic [BC_W-1:0]      line_b,
  output logic                 line_end,
  output logic                 line_head,
  output dsi_tm_pkg::region_e  hreg
);
  import dsi_tm_pkg::*;

  localparam int EW = BC_W + 2;

  logic [EW-1:0]   e_sync, e_back, e_act;
  logic [BC_W-1:0] ht, hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_sync <= '0;
      e_back <= '0;
      e_act  <= '0;
      ht     <= '0;
      hc     <= '0;
    end else if (load) begin
      e_sync <= EW'(part_b[0]);
      e_back <= EW'(part_b[0]) + EW'(part_b[1]);
      e_act  <= EW'(part_b[0]) + EW'(part_b[1]) + EW'(part_b[2]);
      ht     <= line_b;
      hc     <= '0;
    end else if (run) begin
      hc <= line_end ? '0 : hc + 1'b1;
    end
  end

  assign line_end  = run && (hc == ht - 1'b1);
  assign line_head = (hc == '0);

  always_comb begin
    if (EW'(hc) < e_sync)      hreg = RG_SYNC;
    else if (EW'(hc) < e_back) hreg = RG_BACK;
    else if (EW'(hc) < e_act)  hreg = RG_ACT;
    else                       hreg = RG_FRONT;
  end

  assert_hc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hc < ht));
  assert_hc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hc == '0));
endmodule

// File: rtl/dsi_tm_vcnt.sv
// Line counter within a frame, with sampled vertical boundaries.
module dsi_tm_vcnt #(
  parameter int LN_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 load,
  input  logic                 line_end,
  input  logic [3:0][LN_W-1:0] seg_ln,  // sync, back, active, front
  output logic                 frame_end,
  output logic                 first_line,
  output dsi_tm_pkg::region_e  vreg
);
  import dsi_tm_pkg::*;

  localparam int VW = LN_W + 2;

  logic [VW-1:0] e_sync, e_back, e_act, vt, lc, vt_raw;

  assign vt_raw = VW'(seg_ln[0]) + VW'(seg_ln[1]) + VW'(seg_ln[2]) + VW'(seg_ln[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_sync <= '0;
      e_back <= '0;
      e_act  <= '0;
      vt     <= '0;
      lc     <= '0;
    end else if (load) begin
      e_sync <= VW'(seg_ln[0]);
      e_back <= VW'(seg_ln[0]) + VW'(seg_ln[1]);
      e_act  <= VW'(seg_ln[0]) + VW'(seg_ln[1]) + VW'(seg_ln[2]);
      vt     <= (vt_raw == '0) ? VW'(1) : vt_raw;
      lc     <= '0;
    end else if (line_end) begin
      lc <= lc + 1'b1;
    end
  end

  assign frame_end  = line_end && (lc == vt - 1'b1);
  assign first_line = (lc == '0);

  always_comb begin
    if (lc < e_sync)      vreg = RG_SYNC;
    else if (lc < e_back) vreg = RG_BACK;
    else if (lc < e_act)  vreg = RG_ACT;
    else                  vreg = RG_FRONT;
  end

  assert_lc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (lc < vt));
  assert_lc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !line_end && !load) |=> $stable(lc));
endmodule

// File: rtl/dsi_vid_timing.sv
module dsi_vid_timing #(
  parameter int PX_W = 12,
  parameter int LN_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PX_W-1:0] hsa_px,
  input  logic [PX_W-1:0] hbp_px,
  input  logic [PX_W-1:0] hact_px,
  input  logic [PX_W-1:0] hfp_px,
  input  logic [LN_W-1:0] vsa_ln,
  input  logic [LN_W-1:0] vbp_ln,
  input  logic [LN_W-1:0] vact_ln,
  input  logic [LN_W-1:0] vfp_ln,
  input  logic [1:0]      fmt,
  input  logic [1:0]      lanes_m1,
  input  logic            burst,
  output logic [1:0]      vreg,
  output logic [1:0]      hreg,
  output logic            lp_ok,
  output logic            frame_start
);
  import dsi_tm_pkg::*;

  localparam int BC_W = PX_W + 4;

  logic                 run, load, burst_sh;
  logic                 line_end, line_head, frame_end, first_line;
  logic [2:0][BC_W-1:0] part_b;
  logic [BC_W-1:0]      line_b;
  region_e              h_cur, v_cur;

  dsi_tm_conv #(.PX_W(PX_W), .BC_W(BC_W)) u_conv (
    .part_px  ({hact_px, hbp_px, hsa_px}),
    .front_px (hfp_px),
    .fmt      (fmt),
    .lanes_m1 (lanes_m1),
    .part_b   (part_b),
    .line_b   (line_b)
  );

  dsi_tm_hcnt #(.BC_W(BC_W)) u_hcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .load      (load),
    .part_b    (part_b),
    .line_b    (line_b),
    .line_end  (line_end),
    .line_head (line_head),
    .hreg      (h_cur)
  );

  dsi_tm_vcnt #(.LN_W(LN_W)) u_vcnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .load       (load),
    .line_end   (line_end),
    .seg_ln     ({vfp_ln, vact_ln, vbp_ln, vsa_ln}),
    .frame_end  (frame_end),
    .first_line (first_line),
    .vreg       (v_cur)
  );

  // Parameters are sampled on the preload cycle and at each frame end (R9).
  assign load = !run || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      burst_sh <= 1'b0;
    end else begin
      run <= 1'b1;
      if (load) burst_sh <= burst;
    end
  end

  always_comb begin
    vreg        = run ? v_cur : RG_SYNC;
    hreg        = run ? h_cur : RG_SYNC;
    frame_start = run && line_head && first_line;
    if (!run || v_cur != RG_ACT) lp_ok = 1'b1;
    else begin
      case (h_cur)
        RG_BACK:  lp_ok = 1'b1;
        RG_FRONT: lp_ok = burst_sh;
        default:  lp_ok = 1'b0;
      endcase
    end
  end

  assert_fs_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(load));
  assert_burst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> $stable(burst_sh));
  assert_idle_regions_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (vreg == 2'd0 && hreg == 2'd0 && lp_ok && !frame_start));
endmodule

// File: tb/tb_dsi_vid_timing.sv
module tb_dsi_vid_timing;
  localparam int CLK_PERIOD = 10;
  localparam int PX_W = 12;
  localparam int LN_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PX_W-1:0] hsa, hbp, hact, hfp;
  logic [LN_W-1:0] vsa, vbp, vact, vfp;
  logic [1:0] fmt, lanes_m1;
  logic burst;
  logic [1:0] vreg, hreg;
  logic lp_ok, frame_start;

  dsi_vid_timing #(.PX_W(PX_W), .LN_W(LN_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .hsa_px(hsa), .hbp_px(hbp), .hact_px(hact), .hfp_px(hfp),
    .vsa_ln(vsa), .vbp_ln(vbp), .vact_ln(vact), .vfp_ln(vfp),
    .fmt(fmt), .lanes_m1(lanes_m1), .burst(burst),
    .vreg(vreg), .hreg(hreg), .lp_ok(lp_ok), .frame_start(frame_start)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Reference position and sampled parameters.
  bit m_run = 1'b0;
  bit m_burst, m_dirty;
  int m_hc, m_lc, m_he1, m_he2, m_he3, m_ht, m_ve1, m_ve2, m_ve3, m_vt;

  function automatic int to_bytes(int px, int f, int l);
    int b;
    b = (f < 2) ? 24 : (f == 2) ? 18 : 16;
    return (px * b) / (8 * (l + 1));
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_model();
    int f, l;
    f = int'(fmt);
    l = int'(lanes_m1);
    m_he1 = to_bytes(int'(hsa), f, l);
    m_he2 = m_he1 + to_bytes(int'(hbp), f, l);
    m_he3 = m_he2 + to_bytes(int'(hact), f, l);
    m_ht  = to_bytes(int'(hsa) + int'(hbp) + int'(hact) + int'(hfp), f, l);
    if (m_ht == 0) m_ht = 1;
    m_ve1 = int'(vsa);
    m_ve2 = m_ve1 + int'(vbp);
    m_ve3 = m_ve2 + int'(vact);
    m_vt  = m_ve3 + int'(vfp);
    if (m_vt == 0) m_vt = 1;
    m_burst = burst;
    m_dirty = 1'b0;
  endtask

  task automatic step_model();
    bit le, fe;
    le = m_run && (m_hc == m_ht - 1);
    fe = le && (m_lc == m_vt - 1);
    if (!m_run || fe) begin
      load_model();
      m_hc = 0;
      m_lc = 0;
      m_run = 1'b1;
    end else if (le) begin
      m_hc = 0;
      m_lc++;
    end else begin
      m_hc++;
    end
  endtask

  task automatic check_now();
    int eh, ev, elp, efs;
    string sfx;
    if (!m_run) begin
      chk("R1 vreg idle", int'(vreg), 0);
      chk("R1 hreg idle", int'(hreg), 0);
      chk("R1 lp_ok idle", int'(lp_ok), 1);
      chk("R1 frame_start idle", int'(frame_start), 0);
      return;
    end
    sfx = m_dirty ? " R9" : "";
    eh = (m_hc < m_he1) ? 0 : (m_hc < m_he2) ? 1 : (m_hc < m_he3) ? 2 : 3;
    ev = (m_lc < m_ve1) ? 0 : (m_lc < m_ve2) ? 1 : (m_lc < m_ve3) ? 2 : 3;
    if (ev != 2) elp = 1;
    else if (eh == 1) elp = 1;
    else if (eh == 3) elp = int'(m_burst);
    else elp = 0;
    efs = (m_hc == 0 && m_lc == 0) ? 1 : 0;
    chk({"R2 R3 R4 hreg", sfx}, int'(hreg), eh);
    chk({"R5 vreg", sfx}, int'(vreg), ev);
    chk({"R6 R7 lp_ok", sfx}, int'(lp_ok), elp);
    chk({"R8 frame_start", sfx}, int'(frame_start), efs);
  endtask

  task automatic rand_params();
    hsa = PX_W'(1 + $urandom % 6);
    hbp = PX_W'($urandom % 7);
    hact = PX_W'(1 + $urandom % 20);
    hfp = PX_W'($urandom % 7);
    vsa = LN_W'(1 + $urandom % 2);
    vbp = LN_W'($urandom % 3);
    vact = LN_W'(1 + $urandom % 3);
    vfp = LN_W'($urandom % 3);
    fmt = 2'($urandom % 4);
    lanes_m1 = 2'($urandom % 4);
    burst = 1'($urandom % 2);
    if (m_run) m_dirty = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // Corner: 18 bpp on 3 lanes, empty back and front porch, burst on.
    hsa = 12'd3; hbp = 12'd0; hact = 12'd7; hfp = 12'd0;
    vsa = 12'd1; vbp = 12'd0; vact = 12'd2; vfp = 12'd0;
    fmt = 2'd2; lanes_m1 = 2'd2; burst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_now();
    end
    rst_n = 1'b1;
    step_model();
    for (int i = 0; i < 24000; i++) begin
      @(negedge clk);
      check_now();
      if (i == 3000) begin
        // Corner: line of one byte, empty sync and active intervals.
        hsa = 12'd1; hbp = 12'd0; hact = 12'd1; hfp = 12'd0;
        vsa = 12'd1; vbp = 12'd0; vact = 12'd1; vfp = 12'd0;
        fmt = 2'd3; lanes_m1 = 2'd3; burst = 1'b0;
        m_dirty = 1'b1;
      end else if (i == 6000) begin
        // Corner: widest line on one lane at 24 bpp, burst off.
        hsa = 12'd6; hbp = 12'd6; hact = 12'd20; hfp = 12'd6;
        vsa = 12'd2; vbp = 12'd2; vact = 12'd3; vfp = 12'd2;
        fmt = 2'd0; lanes_m1 = 2'd0; burst = 1'b0;
        m_dirty = 1'b1;
      end else if (i > 9000 && ($urandom % 350) == 0) begin
        rand_params();
      end
      step_model();
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule